// File: doc/BRIEF.md
# Bit-Serial Twiddle Product Pair Unit

This unit forms the two twiddle-weighted terms a radix-2 FFT butterfly needs, `A*C - B*S` and `A*C + B*S`, without a hardware multiplier. `C` and `S` are constant cosine and sine coefficients fixed for each instance by parameters. The operands `A` and `B` are two's-complement words. They enter on two single-bit lines, one bit per clock, least significant bit first.

In every clock the current bit of `A` and the current bit of `B` together select one of four precomputed partial sums in each of two small constant tables, one table per output term. The selected value is weighted by the bit position and added into a wide accumulator. At the sign position it is subtracted instead. A start pulse marks the first bit of an operation and clears whatever the previous operation left behind. A one-clock done pulse announces that both parallel results are complete. The results then stay on the outputs until the next start.

Operand width and coefficient width are parameters, so one design serves every stage of a chain whose data grows by one bit per stage. The result words are wide enough that no operand and coefficient combination can overflow.

Top module: `da_bfly_serial`

## Requirements
- R1: When `done_o` is high, `diff_o` equals `A*COS_X - B*SIN_Y` exactly, taken as signed integers. A and B are the two's-complement values of the last OPW bits sampled on `a_bit_i` and `b_bit_i`.
- R2: When `done_o` is high, `sum_o` equals `A*COS_X + B*SIN_Y` exactly, taken as signed integers.
- R3: An operation starts in the clock where `start_i` is high. That clock carries bit 0 (LSB) of both operands. Bit i arrives i clocks later. Bit OPW-1 carries weight -2^(OPW-1).
- R4: `done_o` is high for exactly one clock. It is high in the clock right after the rising edge that sampled bit OPW-1. It is low while the bits are being shifted in.
- R5: Once `done_o` has been high, `diff_o` and `sum_o` hold their values until the next `start_i`. Activity on `a_bit_i` and `b_bit_i` without a start has no effect on them.
- R6: A `start_i` pulse abandons any operation in progress. It also may arrive in the same clock that `done_o` is high. In both cases the next result depends only on the new operation's bits, with no residue from the earlier one.
- R7: Synchronous active-high `rst` sets `done_o` low and both result outputs to zero.
- R8: The result width OPW+CW+1 holds every product pair, including operands of -2^(OPW-1) and 2^(OPW-1)-1, with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Marks the clock carrying bit 0 of both operands |
| a_bit_i | input | 1 | Serial operand A, LSB first |
| b_bit_i | input | 1 | Serial operand B, LSB first |
| diff_o | output | OPW+CW+1 | Signed result A*COS_X - B*SIN_Y |
| sum_o | output | OPW+CW+1 | Signed result A*COS_X + B*SIN_Y |
| done_o | output | 1 | One-clock pulse: results valid |

## Verification
The bench targets the sign position with the extreme operands -128 and 127, in every mix. A design that adds at the sign position instead of subtracting gives results off by 2^OPW times the table value. Too narrow an accumulator wraps on these same cases. The bench also restarts an operation after three bits and chains two operations back to back. A design that fails to clear the accumulator on start carries the old partial sum into the new result. Toggling the operand lines while idle after a result exposes a design that keeps accumulating, or that moves `done_o` by a clock, because both outputs drift away from the expected values.

// File: rtl/da_bfly_pkg.sv
package da_bfly_pkg;

    // Width of the bit-position index carried in the step record.
    localparam int IDX_W = 8;

    // Table address: bit 1 = current A bit, bit 0 = current B bit.
    typedef enum logic [1:0] {
        ADR_NONE = 2'b00,
        ADR_B    = 2'b01,
        ADR_A    = 2'b10,
        ADR_AB   = 2'b11
    } adr_e;

    // Per-clock control record shared by both accumulators.
    typedef struct packed {
        logic             active;  // a serial bit is present this clock
        logic             first;   // bit 0: accumulator restarts from zero
        logic             last;    // sign bit: table value is subtracted
        logic [IDX_W-1:0] idx;     // bit position, used as shift amount
    } step_t;

    // Partial sum held at one table address.
    function automatic int lut_value(adr_e adr, int c, int s, bit neg_s);
        int st;
        st = neg_s ? -s : s;
        case (adr)
            ADR_NONE: return 0;
            ADR_B:    return st;
            ADR_A:    return c;
            default:  return c + st;
        endcase
    endfunction

endpackage

// File: rtl/da_bfly_seq.sv
module da_bfly_seq
    import da_bfly_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    output step_t step_o,
    output logic  done_o
);
    localparam int CNT_W = $clog2(OPW + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx;
    logic             busy_q;
    logic             done_q;

    always_comb begin
        idx           = start_i ? '0 : cnt_q;
        step_o.active = start_i | busy_q;
        step_o.first  = start_i;
        step_o.idx    = IDX_W'(idx);
        step_o.last   = (start_i | busy_q) && (idx == CNT_W'(OPW - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= step_o.last;
            if (step_o.active) begin
                busy_q <= !step_o.last;
                cnt_q  <= idx + 1'b1;
            end
        end
    end

    assign done_o = done_q;

endmodule

// File: rtl/da_bfly_lut.sv
module da_bfly_lut
    import da_bfly_pkg::*;
#(
    parameter int CW      = 10,
    parameter int COS_X   = 236,
    parameter int SIN_Y   = 98,
    parameter bit NEG_SIN = 1'b1
) (
    input  logic              a_bit_i,
    input  logic              b_bit_i,
    output logic signed [CW:0] entry_o
);
    logic signed [CW:0] tbl [4];

    for (genvar k = 0; k < 4; k++) begin : g_ent
        assign tbl[k] = (CW + 1)'(lut_value(adr_e'(2'(k)), COS_X, SIN_Y, NEG_SIN));
    end

    assign entry_o = tbl[{a_bit_i, b_bit_i}];

endmodule

// File: rtl/da_bfly_acc.sv
module da_bfly_acc
    import da_bfly_pkg::*;
#(
    parameter int CW   = 10,
    parameter int ACCW = 19
) (
    input  logic                   clk,
    input  logic                   rst,
    input  step_t                  step_i,
    input  logic signed [CW:0]     entry_i,
    output logic signed [ACCW-1:0] acc_o
);
    logic signed [ACCW-1:0] acc_q;
    logic signed [ACCW-1:0] term;
    logic signed [ACCW-1:0] base;
    logic signed [ACCW-1:0] nxt;

    always_comb begin
        term = {{(ACCW - CW - 1){entry_i[CW]}}, entry_i};
        term = term <<< step_i.idx;
        base = step_i.first ? '0 : acc_q;
        nxt  = step_i.last ? (base - term) : (base + term);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (step_i.active) begin
            acc_q <= nxt;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/da_bfly_serial.sv
module da_bfly_serial
    import da_bfly_pkg::*;
#(
    parameter int OPW   = 8,
    parameter int CW    = 10,
    parameter int COS_X = 236,
    parameter int SIN_Y = 98
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     a_bit_i,
    input  logic                     b_bit_i,
    output logic signed [OPW+CW:0]   diff_o,
    output logic signed [OPW+CW:0]   sum_o,
    output logic                     done_o
);
    localparam int ACCW = OPW + CW + 1;

    step_t                  step;
    logic signed [ACCW-1:0] res [2];

    da_bfly_seq #(.OPW(OPW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .step_o  (step),
        .done_o  (done_o)
    );

    // Branch 0: difference term, branch 1: sum term.
    for (genvar g = 0; g < 2; g++) begin : g_term
        logic signed [CW:0] entry;

        da_bfly_lut #(
            .CW      (CW),
            .COS_X   (COS_X),
            .SIN_Y   (SIN_Y),
            .NEG_SIN (g == 0)
        ) u_lut (
            .a_bit_i (a_bit_i),
            .b_bit_i (b_bit_i),
            .entry_o (entry)
        );

        da_bfly_acc #(.CW(CW), .ACCW(ACCW)) u_acc (
            .clk     (clk),
            .rst     (rst),
            .step_i  (step),
            .entry_i (entry),
            .acc_o   (res[g])
        );
    end

    assign diff_o = res[0];
    assign sum_o  = res[1];

endmodule

// File: rtl/da_bfly_serial_chk.sv
module da_bfly_serial_chk #(
    parameter int OPW   = 8,
    parameter int CW    = 10,
    parameter int COS_X = 236,
    parameter int SIN_Y = 98
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start_i,
    input logic                   a_bit_i,
    input logic                   b_bit_i,
    input logic signed [OPW+CW:0] diff_o,
    input logic signed [OPW+CW:0] sum_o,
    input logic                   done_o
);
    logic [OPW-1:0] a_sh;
    logic [OPW-1:0] b_sh;
    logic [7:0]     bits_q;

    // Last OPW sampled bits, LSB first, so MSB-side entry.
    always_ff @(posedge clk) begin
        a_sh <= {a_bit_i, a_sh[OPW-1:1]};
        b_sh <= {b_bit_i, b_sh[OPW-1:1]};
    end

    // Bits seen since the latest start.
    always_ff @(posedge clk) begin
        if (rst)                                 bits_q <= '0;
        else if (start_i)                        bits_q <= 8'd1;
        else if (bits_q != 0 && bits_q < 8'(OPW)) bits_q <= bits_q + 8'd1;
        else                                     bits_q <= '0;
    end

    p_diff_value_r1: assert property (@(posedge clk) disable iff (rst)
        done_o |-> int'(diff_o) == int'($signed(a_sh)) * COS_X - int'($signed(b_sh)) * SIN_Y);

    p_sum_value_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> int'(sum_o) == int'($signed(a_sh)) * COS_X + int'($signed(b_sh)) * SIN_Y);

    p_done_timing_r4: assert property (@(posedge clk) disable iff (rst)
        done_o == (bits_q == 8'(OPW)));

    p_hold_result_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> ($stable(diff_o) && $stable(sum_o)));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!done_o && diff_o == '0 && sum_o == '0));

endmodule

bind da_bfly_serial da_bfly_serial_chk #(
    .OPW(OPW), .CW(CW), .COS_X(COS_X), .SIN_Y(SIN_Y)
) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .a_bit_i(a_bit_i),
    .b_bit_i(b_bit_i), .diff_o(diff_o), .sum_o(sum_o), .done_o(done_o)
);

// File: tb/da_bfly_serial_tb.sv
`timescale 1ns/1ps
module da_bfly_serial_tb;
    localparam int OPW   = 8;
    localparam int CW    = 10;
    localparam int COS_X = 236;
    localparam int SIN_Y = 98;
    localparam int ACCW  = OPW + CW + 1;

    logic clk = 1'b0;
    logic rst, start, a_bit, b_bit, done;
    logic signed [ACCW-1:0] diff, sum;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    da_bfly_serial #(.OPW(OPW), .CW(CW), .COS_X(COS_X), .SIN_Y(SIN_Y)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .a_bit_i(a_bit), .b_bit_i(b_bit),
        .diff_o(diff), .sum_o(sum), .done_o(done)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_bits(int a, int b, int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            start = (i == 0);
            a_bit = a[i];
            b_bit = b[i];
        end
    endtask

    task automatic idle();
        @(negedge clk);
        start = 1'b0;
        a_bit = 1'b0;
        b_bit = 1'b0;
    endtask

    task automatic check_result(string req, int a, int b);
        check("R4", "done at result", int'(done), 1);
        check(req, "diff", int'(diff), a * COS_X - b * SIN_Y);
        check(req, "sum", int'(sum), a * COS_X + b * SIN_Y);
    endtask

    // One full operation, then one idle clock to confirm the pulse ends.
    task automatic run_op(string req, int a, int b);
        int hd;
        drive_bits(a, b, OPW);
        check("R4", "done low during bits", int'(done), 0);
        idle();
        check_result(req, a, b);
        hd = int'(diff);
        idle();
        check("R4", "done single pulse", int'(done), 0);
        check("R5", "diff held", int'(diff), hd);
    endtask

    task automatic test_reset();
        check("R7", "done after reset", int'(done), 0);
        check("R7", "diff after reset", int'(diff), 0);
        check("R7", "sum after reset", int'(sum), 0);
    endtask

    task automatic test_hold();
        int hd, hs;
        run_op("R1", 5, -3);
        hd = int'(diff);
        hs = int'(sum);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            start = 1'b0;
            a_bit = i[0];
            b_bit = ~i[1];
        end
        @(negedge clk);
        check("R5", "diff unchanged by idle bits", int'(diff), hd);
        check("R5", "sum unchanged by idle bits", int'(sum), hs);
        check("R5", "no done without start", int'(done), 0);
        idle();
    endtask

    task automatic test_restart();
        drive_bits(100, -50, 3);
        drive_bits(-7, 9, OPW);
        check("R6", "done low after restart", int'(done), 0);
        idle();
        check_result("R6", -7, 9);
        idle();
    endtask

    task automatic test_back_to_back();
        drive_bits(-100, 77, OPW);
        @(negedge clk);
        check_result("R6", -100, 77);
        start = 1'b1;
        a_bit = 1'b1;   // bit 0 of 13
        b_bit = 1'b0;   // bit 0 of -6
        for (int i = 1; i < OPW; i++) begin
            @(negedge clk);
            start = 1'b0;
            a_bit = 13 >> i;
            b_bit = -6 >> i;
        end
        idle();
        check_result("R6", 13, -6);
        idle();
    endtask

    task automatic test_extremes();
        run_op("R8", -128, -128);
        run_op("R8", 127, -128);
        run_op("R3", -128, 127);
        run_op("R8", 127, 127);
        run_op("R3", -1, 1);
        run_op("R2", 0, 0);
        run_op("R2", 64, 33);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        a_bit = 1'b0;
        b_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_op("R1", 5, 3);
        test_hold();
        test_extremes();
        test_restart();
        test_back_to_back();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule